// File: doc/BRIEF.md
# Latch-Based Dual-Port Register File

A small storage array of four 4-bit words with a write side and a read side that work on their own. There is no clock. Each word is held in level-sensitive storage. While the active-low write enable is asserted, the word picked by the write address is open and follows the data inputs. When the enable is released, the word keeps the last value it saw. Only one word can be open at a time.

The read side is purely combinational. The read address picks a word through a multiplexer, and an active-low read enable decides whether the outputs drive that word or let the net float. Because the outputs release the net, several files can share one output bus to build a deeper memory, as long as their read enables are never asserted together. A read of the word that is being written passes the incoming data straight through. The contents after power-up are undefined.

Top module: `latch_regfile`

## Requirements
- R1: While wr_en_ni is 0, the word selected by wr_addr_i takes the value on wr_data_i.
- R2: While wr_en_ni stays 0, the addressed word follows every change on wr_data_i.
- R3: While wr_en_ni is 1, changes on wr_data_i and wr_addr_i leave all stored words unchanged.
- R4: When wr_en_ni goes from 0 to 1, the addressed word keeps the last value presented on wr_data_i.
- R5: While rd_en_ni is 0, rd_data_o equals the word selected by rd_addr_i, bit for bit and not inverted.
- R6: While rd_en_ni is 1, rd_data_o releases the net to high impedance on every bit, so another driver on the same net sets its value.
- R7: A word can be read while a different word is being written, and the read returns that word's stored value.
- R8: When rd_addr_i equals wr_addr_i and both enables are 0, rd_data_o shows wr_data_i combinationally.
- R9: Two files whose outputs share one net, with read enables that never overlap, each supply the net with their own addressed word when enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_addr_i | input | 2 | Write word select, held steady while wr_en_ni is 0 |
| wr_data_i | input | 4 | Data to store |
| wr_en_ni | input | 1 | Write enable, active low, level-sensitive |
| rd_addr_i | input | 2 | Read word select |
| rd_en_ni | input | 1 | Output enable, active low |
| rd_data_o | output | 4 | Tri-state read data |

## Verification
Whenever inputs change, the embedded assertions check four things. At most one word is open at a time, and none is open while the write enable is high. An open word holds the write data. The read multiplexer returns the selected stored word, and a matching read and write address passes the write data through. Only the bench's scenarios can show what depends on history or on the shared net: values retained after the enable rises, words left unchanged while inputs move with the enable high, and the output releasing the net so that a second file on the same bus drives it.

// File: rtl/latch_regfile_pkg.sv
package latch_regfile_pkg;
  localparam int unsigned RF_WORDS = 4;
  localparam int unsigned RF_WIDTH = 4;
endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             en_ni,
  output logic [WORDS-1:0] open_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_dec
    assign open_o[g] = !en_ni && (addr_i == AW'(g));
  end
endmodule

// File: rtl/rf_latch_array.sv
module rf_latch_array #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4
) (
  input  logic [WORDS-1:0]            open_i,
  input  logic [WIDTH-1:0]            data_i,
  output logic [WORDS-1:0][WIDTH-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_latch begin
      if (open_i[g]) words_o[g] = data_i;
    end
  end
endmodule

// File: rtl/rf_rd_mux.sv
module rf_rd_mux #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words_i,
  input  logic [AW-1:0]               sel_i,
  output logic [WIDTH-1:0]            word_o
);
  always_comb begin
    word_o = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (sel_i == AW'(i)) word_o = words_i[i];
    end
  end
endmodule

// File: rtl/latch_regfile.sv
module latch_regfile
  import latch_regfile_pkg::*;
#(
  parameter int unsigned WORDS = RF_WORDS,
  parameter int unsigned WIDTH = RF_WIDTH,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             wr_en_ni,
  input  logic [AW-1:0]    rd_addr_i,
  input  logic             rd_en_ni,
  output wire  [WIDTH-1:0] rd_data_o
);
  logic [WORDS-1:0]            word_open;
  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WIDTH-1:0]            rd_word;

  rf_wr_decode #(.WORDS(WORDS)) u_dec (
    .addr_i (wr_addr_i),
    .en_ni  (wr_en_ni),
    .open_o (word_open)
  );

  rf_latch_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arr (
    .open_i  (word_open),
    .data_i  (wr_data_i),
    .words_o (words)
  );

  rf_rd_mux #(.WORDS(WORDS), .WIDTH(WIDTH)) u_mux (
    .words_i (words),
    .sel_i   (rd_addr_i),
    .word_o  (rd_word)
  );

  // release the bus when not selected, for depth expansion
  assign rd_data_o = rd_en_ni ? {WIDTH{1'bz}} : rd_word;

  always_comb begin
    p_single_open_r1: assert ($onehot0(word_open));
    p_closed_when_high_r3: assert (!(wr_en_ni && (word_open != '0)));
    for (int i = 0; i < WORDS; i++) begin
      if (word_open[i]) begin
        p_open_follows_r2: assert (words[i] == wr_data_i);
      end
    end
    p_mux_select_r5: assert (rd_word == words[rd_addr_i]);
    if (!wr_en_ni && !rd_en_ni && rd_addr_i == wr_addr_i) begin
      p_flow_through_r8: assert (rd_word == wr_data_i);
    end
  end
endmodule

// File: tb/sim_latch_regfile.sv
`timescale 1ns/1ps
module sim_latch_regfile;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] wa, ra;
  logic [3:0] wd;
  logic       we_n, re_n;
  logic [1:0] wa1, ra1;
  logic [3:0] wd1;
  logic       we1_n, re1_n;
  wire  [3:0] bus;

  int vecs = 0;
  int errs = 0;
  bit done = 0;
  logic [3:0] model [4];
  logic [3:0] model1 [4];

  latch_regfile u0 (
    .wr_addr_i(wa), .wr_data_i(wd), .wr_en_ni(we_n),
    .rd_addr_i(ra), .rd_en_ni(re_n), .rd_data_o(bus)
  );

  latch_regfile u1 (
    .wr_addr_i(wa1), .wr_data_i(wd1), .wr_en_ni(we1_n),
    .rd_addr_i(ra1), .rd_en_ni(re1_n), .rd_data_o(bus)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr0(input logic [1:0] a, input logic [3:0] d);
    @(posedge clk); wa = a; wd = d;
    @(posedge clk); we_n = 1'b0;
    @(posedge clk); we_n = 1'b1;
    model[a] = d;
  endtask

  task automatic rd0(input string req, input logic [1:0] a, input logic [3:0] exp);
    @(posedge clk); ra = a; re_n = 1'b0;
    @(negedge clk); chk(req, bus, exp);
  endtask

  initial begin
    wa = '0; wd = '0; we_n = 1'b1; ra = '0; re_n = 1'b1;
    wa1 = '0; wd1 = '0; we1_n = 1'b1; ra1 = '0; re1_n = 1'b1;

    // R1 R5: sweep patterns over every word, read back all words
    for (int k = 0; k < 16; k++) begin
      for (int w = 0; w < 4; w++) wr0(2'(w), 4'((k * 5 + w * 3) & 15));
      for (int w = 0; w < 4; w++) rd0("R1/R5", 2'(w), 4'((k * 5 + w * 3) & 15));
    end

    // R2 R8: hold word 2 open, sweep data, read same address
    @(posedge clk); wa = 2'd2; ra = 2'd2; re_n = 1'b0; we_n = 1'b0;
    for (int d = 0; d < 16; d++) begin
      @(posedge clk); wd = 4'(d);
      @(negedge clk); chk("R2/R8", bus, 4'(d));
    end
    @(posedge clk); wd = 4'h9;
    @(posedge clk); we_n = 1'b1;
    model[2] = 4'h9;
    // R4: data changes after release do not reach the word
    @(posedge clk); wd = 4'h6;
    @(negedge clk); chk("R4", bus, 4'h9);

    // R3: inputs move with enable high
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 16; d++) begin
        @(posedge clk); wa = 2'(a); wd = 4'(d);
      end
    end
    for (int w = 0; w < 4; w++) rd0("R3", 2'(w), model[w]);

    // R7 R8: write word 1 while reading every word
    @(posedge clk); wa = 2'd1; wd = 4'hc; we_n = 1'b0;
    for (int w = 0; w < 4; w++) begin
      @(posedge clk); ra = 2'(w);
      @(negedge clk);
      if (w == 1) chk("R8", bus, 4'hc);
      else chk("R7", bus, model[w]);
    end
    @(posedge clk); we_n = 1'b1; model[1] = 4'hc;
    rd0("R7", 2'd1, 4'hc);

    // R6 R9: second file on the shared bus
    for (int w = 0; w < 4; w++) begin
      @(posedge clk); wa1 = 2'(w); wd1 = ~model[w];
      @(posedge clk); we1_n = 1'b0;
      @(posedge clk); we1_n = 1'b1; model1[w] = ~model[w];
    end
    for (int w = 0; w < 4; w++) begin
      @(posedge clk); re_n = 1'b1; ra = 2'(w); ra1 = 2'(w);
      @(posedge clk); re1_n = 1'b0;
      @(negedge clk); chk("R6/R9", bus, model1[w]);
      @(posedge clk); re1_n = 1'b1;
      @(posedge clk); re_n = 1'b0;
      @(negedge clk); chk("R9", bus, model[w]);
    end
    @(posedge clk); re_n = 1'b1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule